// File: doc/BRIEF.md
# ASCII Command Bus Bridge

This block sits between a byte-oriented serial receiver/transmitter pair and an 8-bit internal register bus. It reads the incoming byte stream as short typed text commands and turns each complete command into one register access. A write command names a data value and an address. A read command names only an address. Both use hexadecimal text, with fields separated by single spaces and a carriage return at the end.

Each access is arbitrated with a request/grant pair. The strobe is issued only while the grant is high. For a read, the value that comes back is returned to the transmitter as printable hex text followed by a line break. The serial framing and the register file are outside this block.

Top module: `cmd_bus_bridge`

## Requirements
- R1: The byte sequence 0x77 ('w'), 0x20, one or more hex digits (data), 0x20, one or more hex digits (address), 0x0D produces exactly one single-cycle `bus_wr` pulse. During that pulse `bus_wdata` carries the data and `bus_addr` carries the address.
- R2: The sequence 0x72 ('r'), 0x20, one or more hex digits (address), 0x0D produces exactly one single-cycle `bus_rd` pulse with `bus_addr` set to that address.
- R3: Hex digits are the characters 0x30-0x39 ('0'-'9'), 0x61-0x66 ('a'-'f') and 0x41-0x46 ('A'-'F').
- R4: Each field is built by shifting the value left four bits and inserting each new digit, and only the low 8 bits are kept. A field of four digits therefore yields its last two digits, and a field of one digit yields 0x0 followed by that digit.
- R5: A character that is not allowed in the current parse position returns the parser to idle with no bus access. The next well-formed command is still executed.
- R6: No strobe is issued before the terminating 0x0D. A command without it causes no access.
- R7: `bus_req` rises when a command completes. A strobe is driven only in a cycle where both `bus_req` and `bus_gnt` are high. If `bus_gnt` is already high, the strobe is issued in the first cycle of `bus_req`, two cycles after the cycle in which 0x0D is presented. While `bus_gnt` is low, `bus_req` is held and no strobe is issued. `bus_req` is released after the access.
- R8: `bus_rdata` is sampled in the cycle after `bus_rd`. It is then sent as two lowercase ASCII hex digits, high nibble first, followed by 0x0D and 0x0A.
- R9: `tx_valid` is high only while `tx_busy` is low. A byte held back by `tx_busy` stays on `tx_byte` until it is accepted.
- R10: Bytes that arrive while an access or a response is in progress are ignored and cause no access.
- R11: While `rst` is high and after reset, `bus_req`, `bus_wr`, `bus_rd` and `tx_valid` are low.
- R12: A field with no digits (a separator or terminator directly after a separator) is invalid and causes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| tx_byte | output | 8 | Response character |
| tx_valid | output | 1 | `tx_byte` is offered this cycle |
| tx_busy | input | 1 | Transmitter cannot accept a byte |
| bus_req | output | 1 | Bus access request |
| bus_gnt | input | 1 | Bus access grant |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The bench sends over-long hex fields, mixed-case digits, empty fields, unknown leading characters and a terminator placed inside the data field. A parser that kept the wrong nibbles, rejected uppercase digits or let a malformed line through would issue a wrong or extra strobe. Holding the grant low checks that no strobe leaks out early. Leaving it high checks that no idle cycle is added before the strobe. Holding the transmitter busy during a read reply checks that the first digit stays on the output. The same busy window shows whether a write typed during the reply is wrongly executed. A command left without its terminator must stay silent until the terminator arrives.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  localparam logic [7:0] CH_WR = 8'h77;
  localparam logic [7:0] CH_RD = 8'h72;
  localparam logic [7:0] CH_SP = 8'h20;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;

  typedef enum logic [2:0] {
    P_IDLE, P_W_SEP, P_W_DATA, P_W_ADDR, P_R_SEP, P_R_ADDR
  } parse_st_t;

  typedef enum logic [1:0] {B_IDLE, B_WAIT, B_SAMPLE} bus_st_t;

  function automatic logic hex_is_digit(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h61 && c <= 8'h66) ||
           (c >= 8'h41 && c <= 8'h46);
  endfunction

  function automatic logic [3:0] hex_value(input logic [7:0] c);
    logic [7:0] v;
    if (c <= 8'h39)      v = c - 8'h30;
    else if (c >= 8'h61) v = c - 8'h57;
    else                 v = c - 8'h37;
    return v[3:0];
  endfunction

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h57 + {4'd0, n});
  endfunction
endpackage

// File: rtl/cbb_parser.sv
module cbb_parser
  import cbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        byte_in,
  input  logic              byte_vld,
  input  logic              accept,
  output logic              cmd_go,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  parse_st_t   st;
  logic        seen;
  logic        take, is_dig, is_sp, is_cr;
  logic [3:0]  dig;

  assign take   = byte_vld && accept;
  assign is_dig = hex_is_digit(byte_in);
  assign dig    = hex_value(byte_in);
  assign is_sp  = (byte_in == CH_SP);
  assign is_cr  = (byte_in == CH_CR);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st       <= P_IDLE;
      seen     <= 1'b0;
      cmd_go   <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd_go <= 1'b0;
      if (take) begin
        case (st)
          P_IDLE: begin
            if (byte_in == CH_WR)      st <= P_W_SEP;
            else if (byte_in == CH_RD) st <= P_R_SEP;
          end
          P_W_SEP, P_R_SEP: begin
            if (is_sp) begin
              st       <= (st == P_W_SEP) ? P_W_DATA : P_R_ADDR;
              seen     <= 1'b0;
              cmd_data <= (st == P_W_SEP) ? '0 : cmd_data;
              cmd_addr <= '0;
            end else st <= P_IDLE;
          end
          P_W_DATA: begin
            if (is_dig) begin
              cmd_data <= {cmd_data[DATA_W-5:0], dig};
              seen     <= 1'b1;
            end else if (is_sp && seen) begin
              st   <= P_W_ADDR;
              seen <= 1'b0;
            end else st <= P_IDLE;
          end
          P_W_ADDR, P_R_ADDR: begin
            if (is_dig) begin
              cmd_addr <= {cmd_addr[ADDR_W-5:0], dig};
              seen     <= 1'b1;
            end else if (is_cr && seen) begin
              cmd_go <= 1'b1;
              cmd_rd <= (st == P_R_ADDR);
              st     <= P_IDLE;
            end else st <= P_IDLE;
          end
          default: st <= P_IDLE;
        endcase
      end
    end
  end

  AST_GO_AFTER_CR: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> $past(byte_vld && byte_in == CH_CR)) else $error("go without CR"); // R6
endmodule

// File: rtl/cbb_bus_port.sv
module cbb_bus_port
  import cbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              rd_done,
  output logic              busy
);
  bus_st_t st;
  logic    is_rd;
  logic    fire;

  assign fire    = (st == B_WAIT) && bus_gnt;
  assign bus_req = (st != B_IDLE);
  assign bus_wr  = fire && !is_rd;
  assign bus_rd  = fire && is_rd;
  assign rd_done = (st == B_SAMPLE);
  assign busy    = (st != B_IDLE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st        <= B_IDLE;
      is_rd     <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (st)
        B_IDLE: if (cmd_go) begin
          st        <= B_WAIT;
          is_rd     <= cmd_rd;
          bus_addr  <= cmd_addr;
          bus_wdata <= cmd_data;
        end
        B_WAIT:   if (fire) st <= is_rd ? B_SAMPLE : B_IDLE;
        B_SAMPLE: st <= B_IDLE;
        default:  st <= B_IDLE;
      endcase
    end
  end

  AST_STROBE_NEEDS_GNT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |-> (bus_req && bus_gnt)) else $error("strobe w/o grant"); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd)) else $error("both strobes"); // R7
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) |=> !(bus_wr || bus_rd)) else $error("strobe > 1 cycle"); // R1
  AST_RD_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (rd_done && bus_req)) else $error("no sample after read"); // R8
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_go |-> !busy) else $error("command while busy"); // R10
endmodule

// File: rtl/cbb_resp_tx.sv
module cbb_resp_tx
  import cbb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] value,
  input  logic              tx_busy,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              active
);
  localparam int NDIG   = DATA_W / 4;
  localparam int NBYTES = NDIG + 2;
  localparam int IW     = $clog2(NBYTES);
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  logic [DATA_W-1:0] shadow;
  logic [IW-1:0]     idx;
  logic              sent;

  assign tx_valid = active && !tx_busy;
  assign sent     = tx_valid;

  always_comb begin
    logic [DATA_W-1:0] sh;
    sh = shadow >> (4 * (NDIG - 1 - int'(idx)));
    if (int'(idx) < NDIG)      tx_byte = nib_to_ascii(sh[3:0]);
    else if (int'(idx) == NDIG) tx_byte = CH_CR;
    else                        tx_byte = CH_LF;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shadow <= '0;
      idx    <= '0;
      active <= 1'b0;
    end else if (load) begin
      shadow <= value;
      idx    <= '0;
      active <= 1'b1;
    end else if (sent) begin
      idx <= idx + 1'b1;
      if (idx == LAST) active <= 1'b0;
    end
  end

  AST_TX_RESPECTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !tx_busy) else $error("tx while busy"); // R9
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
    (active && tx_busy && !load) |=> $stable(tx_byte)) else $error("byte changed"); // R9
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !active) else $error("load during reply"); // R10
endmodule

// File: rtl/cmd_bus_bridge.sv
module cmd_bus_bridge
  import cbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic              cmd_go, cmd_rd, rd_done, bus_busy, resp_active, accept;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;

  assign accept = !bus_busy && !resp_active && !cmd_go;

  cbb_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parse (
    .clk(clk), .rst(rst), .byte_in(rx_byte), .byte_vld(rx_valid), .accept(accept),
    .cmd_go(cmd_go), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  cbb_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .bus_gnt(bus_gnt), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_done(rd_done), .busy(bus_busy)
  );

  cbb_resp_tx #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .load(rd_done), .value(bus_rdata), .tx_busy(tx_busy),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .active(resp_active)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !(bus_req || bus_wr || bus_rd || tx_valid)) else $error("active in reset"); // R11
endmodule

// File: tb/tb_cmd_bus_bridge.sv
`timescale 1ns/1ps
module tb_cmd_bus_bridge;
  logic       clk = 0, rst = 1;
  logic [7:0] rx_byte = 0;
  logic       rx_valid = 0, tx_busy = 0, bus_gnt = 1;
  logic [7:0] tx_byte, bus_addr, bus_wdata, bus_rdata;
  logic       tx_valid, bus_req, bus_wr, bus_rd;

  always #4 clk = ~clk;

  cmd_bus_bridge dut (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_busy(tx_busy), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata)
  );

  int tests = 0, fails = 0;
  logic [7:0] mem [256];
  int wr_cnt = 0, rd_cnt = 0, tx_n = 0;
  logic [7:0] l_addr, l_data, l_raddr;
  logic [7:0] txb [64];
  logic req_q = 0, first_cyc = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (bus_wr) begin
      mem[bus_addr] <= bus_wdata; wr_cnt <= wr_cnt + 1;
      l_addr <= bus_addr; l_data <= bus_wdata; first_cyc <= !req_q;
    end
    if (bus_rd) begin
      bus_rdata <= mem[bus_addr]; rd_cnt <= rd_cnt + 1;
      l_raddr <= bus_addr; first_cyc <= !req_q;
    end
    if (tx_valid && !tx_busy) begin txb[tx_n] <= tx_byte; tx_n <= tx_n + 1; end
    req_q <= bus_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_text(input logic [95:0] t);
    for (int i = 11; i >= 0; i--) if (t[i*8 +: 8] != 8'h00) send_byte(t[i*8 +: 8]);
  endtask

  // kind: 0 none, 1 write, 2 read (data = expected reply value)
  localparam int NV = 10;
  localparam logic [95:0] V_TXT [NV] = '{
    {"w 4cd9 1a", 8'h0d}, {"r 1a", 8'h0d}, {"w A5 FF", 8'h0d}, {"r Ff", 8'h0d},
    {"w 7 3", 8'h0d},     {"r 3", 8'h0d},  {"w 1g 2", 8'h0d},  {"r ", 8'h0d},
    {"q 1", 8'h0d},       {"w 12", 8'h0d}};
  localparam logic [1:0] V_KIND [NV] = '{1, 2, 1, 2, 1, 2, 0, 0, 0, 0};
  localparam logic [7:0] V_ADDR [NV] = '{8'h1a, 8'h1a, 8'hff, 8'hff, 8'h03, 8'h03, 0, 0, 0, 0};
  localparam logic [7:0] V_DATA [NV] = '{8'hd9, 8'hd9, 8'ha5, 8'ha5, 8'h07, 8'h07, 0, 0, 0, 0};

  task automatic check_reply(input logic [7:0] v, input int base);
    string s;
    s = $sformatf("%02h", v);
    chk("R8 reply count", tx_n - base, 4);
    chk("R8 hi digit", txb[base], s[0]);
    chk("R8 lo digit", txb[base+1], s[1]);
    chk("R8 CR", txb[base+2], 8'h0d);
    chk("R8 LF", txb[base+3], 8'h0a);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int w0, r0, t0;
    repeat (3) @(negedge clk);
    chk("R11 req in reset", bus_req, 0);
    chk("R11 strobes in reset", {bus_wr, bus_rd}, 0);
    chk("R11 tx_valid in reset", tx_valid, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R11 req after reset", bus_req, 0);

    // table: R1 R2 R3 R4 R5 R12 R7
    for (int i = 0; i < NV; i++) begin
      w0 = wr_cnt; r0 = rd_cnt; t0 = tx_n;
      send_text(V_TXT[i]);
      repeat (12) @(negedge clk);
      case (V_KIND[i])
        2'd1: begin
          chk("R1 one write", wr_cnt - w0, 1);
          chk("R1/R4 write addr", l_addr, V_ADDR[i]);
          chk("R1/R3 write data", l_data, V_DATA[i]);
          chk("R7 no stall", first_cyc, 1);
        end
        2'd2: begin
          chk("R2 one read", rd_cnt - r0, 1);
          chk("R2/R3 read addr", l_raddr, V_ADDR[i]);
          check_reply(V_DATA[i], t0);
        end
        default: begin
          chk("R5/R12 no write", wr_cnt - w0, 0);
          chk("R5/R12 no read", rd_cnt - r0, 0);
        end
      endcase
      chk("R7 req released", bus_req, 0);
    end

    // R6: no access until terminator
    w0 = wr_cnt;
    send_text("w 12 34");
    repeat (10) @(negedge clk);
    chk("R6 no write before CR", wr_cnt - w0, 0);
    send_byte(8'h0d);
    repeat (6) @(negedge clk);
    chk("R6 write after CR", wr_cnt - w0, 1);
    chk("R6 addr", l_addr, 8'h34);
    chk("R6 data", l_data, 8'h12);

    // R7: grant held low
    bus_gnt = 0; w0 = wr_cnt;
    send_text({"w 11 22", 8'h0d});
    repeat (8) @(negedge clk);
    chk("R7 no strobe w/o grant", wr_cnt - w0, 0);
    chk("R7 req held", bus_req, 1);
    bus_gnt = 1;
    repeat (4) @(negedge clk);
    chk("R7 write after grant", wr_cnt - w0, 1);
    chk("R7 addr after grant", l_addr, 8'h22);
    chk("R7 stalled strobe", first_cyc, 0);
    chk("R7 req dropped", bus_req, 0);

    // R9 / R10: busy transmitter, bytes ignored during reply
    tx_busy = 1; w0 = wr_cnt; t0 = tx_n;
    send_text({"r 1a", 8'h0d});
    repeat (4) @(negedge clk);
    chk("R9 valid low while busy", tx_valid, 0);
    chk("R9 held byte", tx_byte, 8'h64);
    send_text({"w 5 6", 8'h0d});
    chk("R9 nothing sent", tx_n - t0, 0);
    tx_busy = 0;
    repeat (10) @(negedge clk);
    check_reply(8'hd9, t0);
    chk("R10 ignored write", wr_cnt - w0, 0);
    w0 = wr_cnt;
    send_text({"w 5 6", 8'h0d});
    repeat (6) @(negedge clk);
    chk("R10 later write works", wr_cnt - w0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule